// File: doc/BRIEF.md
# RS-232 Transceiver Power Manager

This block is the digital controller for a multi-channel serial line transceiver. Each receiver has an analog front end that reports whether a valid line level is present. The block takes one flag per receiver and, from those flags and three control pins, it drives four outputs: the charge-pump enable, the transmitter output enable, the receiver output enable and a line-status flag, `link_ok`. `link_ok` is high while a valid level is seen and low after the line has gone quiet.

Detection is deliberately asymmetric. The line is declared lost only after every receiver has stayed invalid for more than `LOSS_US` microseconds without a break. It is declared present again after any single receiver has shown a valid level for `VALID_US` microseconds.

A low `force_off_n` shuts the supplies and the drivers down, whatever else is happening. A high `force_on` keeps them running. With neither pin active, the supplies follow `link_ok`. Whenever power is switched on, the transmitters stay off until `WAKE_US` microseconds have passed and the supply model reports `supply_ready`. All intervals are measured in microseconds, derived from `CLK_PER_US` clock cycles each.

Top module: `rs232_pwr_ctrl`

## Requirements
- R1: `link_ok` falls only after the synchronized receiver flags have all been low for LOSS_US*CLK_PER_US consecutive cycles. From the cycle the flags drop at the pins, the fall comes exactly LOSS_US*CLK_PER_US+3 rising edges later. Any valid cycle inside that window restarts the count.
- R2: `link_ok` rises when at least one receiver flag (any bit) has been high for VALID_US*CLK_PER_US consecutive synchronized cycles. The rise comes exactly VALID_US*CLK_PER_US+3 edges after the flag rises at the pin. A shorter pulse leaves `link_ok` low.
- R3: While `force_off_n` is low, `pump_en` and `tx_oe` are low from the next edge on, whatever `force_on` and the line state are.
- R4: With `force_off_n` high and `force_on` high, `pump_en` is high from the next edge on, whether or not a valid level is present.
- R5: With `force_off_n` high and `force_on` low (automatic mode), the supplies are powered if and only if `link_ok` is high, one edge later.
- R6: `rx_oe` is the inverse of `rx_en_n` in every power state.
- R7: After `pump_en` rises, `tx_oe` stays low for WAKE_US*CLK_PER_US edges. It rises on the first edge after that delay at which `supply_ready` is high. `tx_oe` is never high while `pump_en` is low.
- R8: `link_ok` follows the line in every mode: forced on, forced off and automatic.
- R9: In automatic mode, a valid burst long enough to power the block up, followed by silence, powers the block down again after the loss window of R1.
- R10: After reset, `link_ok`, `pump_en` and `tx_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid_async | input | NUM_RX | Per-receiver valid-level flag; asynchronous |
| force_off_n | input | 1 | Active-low manual shutdown; has the highest priority |
| force_on | input | 1 | Active-high keep-alive; disables automatic power-down |
| rx_en_n | input | 1 | Active-low receiver output enable |
| supply_ready | input | 1 | Internal supplies are above the transmit threshold; tie high to use the delay alone |
| pump_en | output | 1 | Charge-pump enable |
| tx_oe | output | 1 | Transmitter output enable |
| rx_oe | output | 1 | Receiver output enable |
| link_ok | output | 1 | High while a valid line level is present |

## Verification
The hardest case to reach from the ports is a restarted loss window. The line must go quiet long enough to be well into the window, show a valid level briefly (shorter than would power the block up from cold), then go quiet again. The bench builds this sequence with exact edge counts. It then checks that `link_ok` is still high at a point where an unrestarted count would already have dropped it, and that it falls exactly one full window after the second silence began. Sub-microsecond glitches are driven the same way, and the sweep over all sixteen combinations of control pins and line state settles long enough for both the loss window and the wake delay to expire.

// File: rtl/rs232_pwr_pkg.sv
package rs232_pwr_pkg;

  // Power sequencer states
  typedef enum logic [1:0] {
    PS_OFF  = 2'd0,
    PS_WAKE = 2'd1,
    PS_ON   = 2'd2
  } pwr_state_e;

  // Supplies are wanted when not forced off and either forced on or the line is live
  function automatic logic power_wanted(input logic force_off_n,
                                        input logic force_on,
                                        input logic link_ok);
    return force_off_n && (force_on || link_ok);
  endfunction

endpackage

// File: rtl/rs232_pwr_us_timer.sv
// Counts run cycles in whole microseconds; done is sticky until clr.
module rs232_pwr_us_timer #(
  parameter int CLK_PER_US = 100,
  parameter int TARGET_US  = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic done
);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int UW = (TARGET_US > 1) ? $clog2(TARGET_US) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_US - 1);
  localparam logic [UW-1:0] US_LAST  = UW'(TARGET_US - 1);

  logic [PW-1:0] pre_q;
  logic [UW-1:0] us_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      us_q  <= '0;
      done  <= 1'b0;
    end else if (clr) begin
      pre_q <= '0;
      us_q  <= '0;
      done  <= 1'b0;
    end else if (!done) begin
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        if (us_q == US_LAST) done <= 1'b1;
        else                 us_q <= us_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs232_pwr_line_detect.sv
// Synchronizes receiver flags and filters them into a single line-status bit.
module rs232_pwr_line_detect #(
  parameter int NUM_RX     = 2,
  parameter int CLK_PER_US = 100,
  parameter int LOSS_US    = 30,
  parameter int VALID_US   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_RX-1:0] rx_valid_async,
  output logic              link_ok
);
  logic [NUM_RX-1:0] meta_q;
  logic [NUM_RX-1:0] sync_q;

  for (genvar g = 0; g < NUM_RX; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        sync_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= rx_valid_async[g];
        sync_q[g] <= meta_q[g];
      end
    end
  end

  logic any_valid;
  assign any_valid = |sync_q;

  logic loss_clr, loss_done;
  logic seen_clr, seen_done;
  assign loss_clr = any_valid || !link_ok;
  assign seen_clr = !any_valid || link_ok;

  rs232_pwr_us_timer #(.CLK_PER_US(CLK_PER_US), .TARGET_US(LOSS_US)) u_loss (
    .clk(clk), .rst_n(rst_n), .clr(loss_clr), .done(loss_done)
  );

  rs232_pwr_us_timer #(.CLK_PER_US(CLK_PER_US), .TARGET_US(VALID_US)) u_seen (
    .clk(clk), .rst_n(rst_n), .clr(seen_clr), .done(seen_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 link_ok <= 1'b0;
    else if (link_ok && loss_done && !any_valid) link_ok <= 1'b0;
    else if (!link_ok && seen_done && any_valid) link_ok <= 1'b1;
  end
endmodule

// File: rtl/rs232_pwr_seq.sv
// Power sequencer: off, waiting for supplies, on.
module rs232_pwr_seq
  import rs232_pwr_pkg::*;
#(
  parameter int CLK_PER_US = 100,
  parameter int WAKE_US    = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic force_off_n,
  input  logic force_on,
  input  logic link_ok,
  input  logic supply_ready,
  output logic pump_en,
  output logic tx_oe
);
  pwr_state_e state_q, state_d;
  logic want_on, wake_done, wake_clr;

  assign want_on  = power_wanted(force_off_n, force_on, link_ok);
  assign wake_clr = (state_q != PS_WAKE);

  rs232_pwr_us_timer #(.CLK_PER_US(CLK_PER_US), .TARGET_US(WAKE_US)) u_wake (
    .clk(clk), .rst_n(rst_n), .clr(wake_clr), .done(wake_done)
  );

  always_comb begin
    state_d = state_q;
    if (!want_on) begin
      state_d = PS_OFF;
    end else begin
      unique case (state_q)
        PS_OFF:  state_d = PS_WAKE;
        PS_WAKE: if (wake_done && supply_ready) state_d = PS_ON;
        PS_ON:   state_d = PS_ON;
        default: state_d = PS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_OFF;
    else        state_q <= state_d;
  end

  assign pump_en = (state_q != PS_OFF);
  assign tx_oe   = (state_q == PS_ON);
endmodule

// File: rtl/rs232_pwr_ctrl.sv
module rs232_pwr_ctrl #(
  parameter int NUM_RX     = 2,
  parameter int CLK_PER_US = 100,
  parameter int LOSS_US    = 30,
  parameter int VALID_US   = 1,
  parameter int WAKE_US    = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_RX-1:0] rx_valid_async,
  input  logic              force_off_n,
  input  logic              force_on,
  input  logic              rx_en_n,
  input  logic              supply_ready,
  output logic              pump_en,
  output logic              tx_oe,
  output logic              rx_oe,
  output logic              link_ok
);
  rs232_pwr_line_detect #(
    .NUM_RX(NUM_RX), .CLK_PER_US(CLK_PER_US),
    .LOSS_US(LOSS_US), .VALID_US(VALID_US)
  ) u_detect (
    .clk(clk), .rst_n(rst_n), .rx_valid_async(rx_valid_async), .link_ok(link_ok)
  );

  rs232_pwr_seq #(.CLK_PER_US(CLK_PER_US), .WAKE_US(WAKE_US)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .force_off_n(force_off_n), .force_on(force_on),
    .link_ok(link_ok), .supply_ready(supply_ready),
    .pump_en(pump_en), .tx_oe(tx_oe)
  );

  // Receiver output enable does not depend on the power state
  assign rx_oe = ~rx_en_n;
endmodule

// File: rtl/rs232_pwr_ctrl_chk.sv
module rs232_pwr_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic force_off_n,
  input logic force_on,
  input logic supply_ready,
  input logic pump_en,
  input logic tx_oe,
  input logic link_ok
);
  AST_FORCE_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    !force_off_n |=> (!pump_en && !tx_oe)); // R3
  AST_FORCE_ON_POWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (force_off_n && force_on) |=> pump_en); // R4
  AST_AUTO_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (force_off_n && !force_on && !link_ok) |=> !pump_en); // R5
  AST_AUTO_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (force_off_n && link_ok) |=> pump_en); // R5
  AST_TX_NEEDS_PUMP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_oe |-> pump_en); // R7
  AST_TX_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_oe) |-> $past(supply_ready)); // R7
  AST_WAKE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pump_en) |=> !tx_oe); // R7
endmodule

bind rs232_pwr_ctrl rs232_pwr_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .force_off_n(force_off_n), .force_on(force_on),
  .supply_ready(supply_ready), .pump_en(pump_en), .tx_oe(tx_oe), .link_ok(link_ok)
);

// File: tb/rs232_pwr_ctrl_tb.sv
module rs232_pwr_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NRX   = 2;
  localparam int CPU   = 4;
  localparam int LOSS  = 30;
  localparam int VALID = 1;
  localparam int WAKE  = 100;
  localparam int T_LOSS  = LOSS * CPU;
  localparam int T_VALID = VALID * CPU;
  localparam int T_WAKE  = WAKE * CPU;
  localparam int SETTLE  = T_LOSS + T_WAKE + 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NRX-1:0] rx_valid_async = '0;
  logic force_off_n = 1'b1, force_on = 1'b0, rx_en_n = 1'b0, supply_ready = 1'b1;
  logic pump_en, tx_oe, rx_oe, link_ok;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs232_pwr_ctrl #(.NUM_RX(NRX), .CLK_PER_US(CPU), .LOSS_US(LOSS),
                   .VALID_US(VALID), .WAKE_US(WAKE)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid_async(rx_valid_async),
    .force_off_n(force_off_n), .force_on(force_on), .rx_en_n(rx_en_n),
    .supply_ready(supply_ready), .pump_en(pump_en), .tx_oe(tx_oe),
    .rx_oe(rx_oe), .link_ok(link_ok)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R10 reset state
    chk("R10", "link_ok", link_ok, 1'b0);
    chk("R10", "pump_en", pump_en, 1'b0);
    chk("R10", "tx_oe", tx_oe, 1'b0);
    chk("R6", "rx_oe enabled", rx_oe, 1'b1);

    // R2 glitch shorter than VALID window is ignored
    rx_valid_async = 2'b10;
    step(T_VALID - 2);
    rx_valid_async = 2'b00;
    step(30);
    chk("R2", "short pulse ignored", link_ok, 1'b0);
    chk("R5", "no power after glitch", pump_en, 1'b0);

    // R2 exact rise timing on receiver 0
    rx_valid_async = 2'b01;
    step(T_VALID + 2);
    chk("R2", "link before rise edge", link_ok, 1'b0);
    step(1);
    chk("R2", "link at rise edge", link_ok, 1'b1);
    // R5 and R7 wake sequence in automatic mode
    step(1);
    chk("R5", "pump follows link", pump_en, 1'b1);
    chk("R7", "tx held during wake", tx_oe, 1'b0);
    step(T_WAKE);
    chk("R7", "tx before wake end", tx_oe, 1'b0);
    step(1);
    chk("R7", "tx after wake", tx_oe, 1'b1);

    // R1 exact fall timing
    rx_valid_async = 2'b00;
    step(T_LOSS + 2);
    chk("R1", "link before loss edge", link_ok, 1'b1);
    step(1);
    chk("R1", "link at loss edge", link_ok, 1'b0);
    step(1);
    chk("R5", "pump off after loss", pump_en, 1'b0);
    chk("R5", "tx off after loss", tx_oe, 1'b0);

    // R1 loss window restarts on a brief valid level
    rx_valid_async = 2'b10;
    step(20);
    chk("R1", "link up for restart test", link_ok, 1'b1);
    rx_valid_async = 2'b00;
    step(60);
    rx_valid_async = 2'b01;
    step(2);
    rx_valid_async = 2'b00;
    step(T_LOSS - 10);
    chk("R1", "window restarted", link_ok, 1'b1);
    step(12);
    chk("R1", "link before restarted end", link_ok, 1'b1);
    step(1);
    chk("R1", "link at restarted end", link_ok, 1'b0);

    // R9 burst powers up, silence powers back down
    step(SETTLE);
    rx_valid_async = 2'b01;
    step(8);
    rx_valid_async = 2'b00;
    chk("R9", "powered after burst", pump_en, 1'b1);
    step(T_LOSS + 20);
    chk("R9", "link lost after burst", link_ok, 1'b0);
    chk("R9", "powered down again", pump_en, 1'b0);
    chk("R9", "tx off again", tx_oe, 1'b0);

    // Truth-table sweep: R3 R4 R5 R6 R8
    for (int code = 0; code < 16; code++) begin
      logic fo, fon, en, line, pw;
      fo   = code[3];
      fon  = code[2];
      en   = code[1];
      line = code[0];
      force_off_n = fo;
      force_on = fon;
      rx_en_n = en;
      rx_valid_async = line ? 2'b10 : 2'b00;
      step(SETTLE);
      pw = fo && (fon || line);
      chk(fo ? (fon ? "R4" : "R5") : "R3", "sweep pump_en", pump_en, pw);
      chk(fo ? (fon ? "R4" : "R5") : "R3", "sweep tx_oe", tx_oe, pw);
      chk("R6", "sweep rx_oe", rx_oe, ~en);
      chk("R8", "sweep link_ok", link_ok, line);
    end

    // R7 supply-ready gate
    force_off_n = 1'b0;
    step(2);
    supply_ready = 1'b0;
    rx_en_n = 1'b0;
    rx_valid_async = 2'b00;
    force_off_n = 1'b1;
    force_on = 1'b1;
    step(T_WAKE + 50);
    chk("R7", "pump on without supply", pump_en, 1'b1);
    chk("R7", "tx waits for supply", tx_oe, 1'b0);
    supply_ready = 1'b1;
    step(1);
    chk("R7", "tx after supply ready", tx_oe, 1'b1);

    // R3 force-off while running, line state untouched (R8)
    rx_valid_async = 2'b01;
    step(20);
    force_off_n = 1'b0;
    step(1);
    chk("R3", "pump off next edge", pump_en, 1'b0);
    chk("R3", "tx off next edge", tx_oe, 1'b0);
    chk("R8", "link unaffected by force-off", link_ok, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule